// File: doc/BRIEF.md
# Delayed Bidirectional Request Bridge

This block joins two request buses, called side A and side B. A request taken in on A is sent out on B, and a request taken in on B is sent out on A. Each direction keeps its own inbound queue. Every accepted request is stamped with the value of a free-running cycle counter. It is released toward the far side only after it has aged by a fixed number of clock cycles. When that delay is set to zero, the inbound queue is left out and the request is offered to the far side in the cycle it arrives.

If the far side refuses an offered request, the request moves to a retry list for that side. It is sent again, oldest first, when the far side raises its retry input. A resent request carries a flag, and the consumer must take it. Each source side sees a hold level. Hold rises when the number of requests in flight in that direction (inbound queue plus far-side retry list) reaches the direction's capacity. Hold falls once that number drops below the capacity. Status codes from a neighbour are relayed to the opposite side, except the two block/unblock codes, which the bridge absorbs.

Top module: `dly_xbridge`

## Requirements
- R1: Each request accepted on one side leaves on the other side exactly once, with address, size and data unchanged. Within one direction, requests leave in the order they were accepted, including requests that went through the retry list.
- R2: With DELAY greater than zero, a request is never delivered fewer than DELAY cycles after its accepting clock edge. On an idle bridge whose far side is ready, the offer appears in the cycle that begins DELAY edges after the accepting edge. This holds at any counter value, including across counter wrap.
- R3: The two directions have separate capacities CAP_AB and CAP_BA (default 16). The number of requests in flight in a direction never exceeds its capacity.
- R4: The hold output of a source side is high exactly when the in-flight count of its direction, as it stood at the previous clock edge, is at or above the capacity. It is low otherwise, so it changes state only when the count crosses the capacity.
- R5: While a side's hold is high, its input ready is low. A request offered there has no effect: it is never delivered and the in-flight count does not grow.
- R6: An offer that is not resent and sees ready low at its clock edge goes to the retry list. When retry is high and the list is not empty, the list head is presented with the resend flag set and counts as taken. The resend flag is never high while retry is low.
- R7: While a direction's retry list is not empty, newly eligible requests join the back of that list instead of being offered directly.
- R8: With DELAY equal to zero, an accepted request is presented on the far side in the same cycle when that side's retry list is empty.
- R9: A status input with code 1 (blocked) or 2 (unblocked) is absorbed. Code 0 (range change) or 3 (other) appears on the opposite side's status output one cycle later with the same code.
- R10: After reset, both holds are low, both input readies are high, and no request or status output is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in_vld | input | 1 | Request offered on side A |
| a_in_rdy | output | 1 | Side A request taken |
| a_in_addr | input | AW | Side A request address |
| a_in_size | input | SW | Side A request size |
| a_in_data | input | DW | Side A request payload |
| a_out_vld | output | 1 | Request presented toward side A |
| a_out_rdy | input | 1 | Side A consumer takes a non-resent request |
| a_out_resend | output | 1 | Presented request comes from the retry list (must be taken) |
| a_retry | input | 1 | Side A consumer asks for a resend |
| a_out_addr | output | AW | Outgoing address on side A |
| a_out_size | output | SW | Outgoing size on side A |
| a_out_data | output | DW | Outgoing payload on side A |
| a_hold | output | 1 | Side A source is blocked |
| a_st_in_vld | input | 1 | Status from side A neighbour valid |
| a_st_in_code | input | 2 | Status code from side A neighbour |
| a_st_out_vld | output | 1 | Relayed status toward side A valid |
| a_st_out_code | output | 2 | Relayed status code toward side A |
| b_in_vld | input | 1 | Request offered on side B |
| b_in_rdy | output | 1 | Side B request taken |
| b_in_addr | input | AW | Side B request address |
| b_in_size | input | SW | Side B request size |
| b_in_data | input | DW | Side B request payload |
| b_out_vld | output | 1 | Request presented toward side B |
| b_out_rdy | input | 1 | Side B consumer takes a non-resent request |
| b_out_resend | output | 1 | Presented request comes from the retry list (must be taken) |
| b_retry | input | 1 | Side B consumer asks for a resend |
| b_out_addr | output | AW | Outgoing address on side B |
| b_out_size | output | SW | Outgoing size on side B |
| b_out_data | output | DW | Outgoing payload on side B |
| b_hold | output | 1 | Side B source is blocked |
| b_st_in_vld | input | 1 | Status from side B neighbour valid |
| b_st_in_code | input | 2 | Status code from side B neighbour |
| b_st_out_vld | output | 1 | Relayed status toward side B valid |
| b_st_out_code | output | 2 | Relayed status code toward side B |

## Verification
The hardest state to reach is a full direction whose in-flight requests are split between the inbound queue and the retry list. It must also have eligible requests arriving behind a non-empty retry list while a resend drains that list in the same cycle. Random phases keep the consumer's ready low about half the time and raise retry rarely. This piles refused requests into the retry list while new ones keep ageing behind them, and the smaller B-to-A capacity makes hold toggle often. Directed phases then starve one consumer until the source is held, offer further requests against the hold, and drain through retry alone. A second instance with zero delay checks the same-cycle path and its refusal into the retry list.

// File: rtl/xb_pkg.sv
package xb_pkg;

    typedef enum logic [1:0] {
        ST_RANGE   = 2'd0,
        ST_BLOCK   = 2'd1,
        ST_UNBLOCK = 2'd2,
        ST_OTHER   = 2'd3
    } xb_stat_e;

    // Wrap-safe age test: (now - stamp) modulo the counter width against the delay.
    function automatic logic aged(input logic [31:0] now, input logic [31:0] stamp,
                                  input logic [31:0] mask, input logic [31:0] dly);
        return ((now - stamp) & mask) >= dly;
    endfunction

    function automatic logic absorbed(input logic [1:0] code);
        return (xb_stat_e'(code) == ST_BLOCK) || (xb_stat_e'(code) == ST_UNBLOCK);
    endfunction

endpackage

// File: rtl/xb_fifo.sv
module xb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH+1);

    logic [W-1:0]    mem [DEPTH];
    logic [PTRW-1:0] wp, rp;

    function automatic logic [PTRW-1:0] step_ptr(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH-1)) ? '0 : p + PTRW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= step_ptr(wp);
            if (pop)  rp <= step_ptr(rp);
            count <= count + CNTW'(push) - CNTW'(pop);
        end
    end

    assign dout = mem[rp];
endmodule

// File: rtl/xb_lane.sv
module xb_lane #(
    parameter int PAYW  = 8,
    parameter int DELAY = 4,
    parameter int CAP   = 16,
    parameter int CW    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW-1:0]   now,
    input  logic            in_vld,
    output logic            in_rdy,
    input  logic [PAYW-1:0] in_pay,
    output logic            out_vld,
    input  logic            out_rdy,
    output logic            out_resend,
    input  logic            retry,
    output logic [PAYW-1:0] out_pay,
    output logic            hold
);
    localparam int CNTW = $clog2(CAP+1);
    localparam int OW   = CNTW + 1;

    logic            hold_q, acc, resend, fresh, del;
    logic            rt_push;
    logic [PAYW-1:0] rt_din, rt_head, fresh_pay;
    logic [CNTW-1:0] rt_cnt;
    logic [OW-1:0]   occ, sum_next;

    assign in_rdy = !hold_q;
    assign hold   = hold_q;
    assign acc    = in_vld && !hold_q;
    assign resend = retry && (rt_cnt != '0);

    xb_fifo #(.W(PAYW), .DEPTH(CAP)) u_retry (
        .clk(clk), .rst(rst), .push(rt_push), .din(rt_din),
        .pop(resend), .dout(rt_head), .count(rt_cnt)
    );

    generate
        if (DELAY > 0) begin : g_timed
            localparam int EW = CW + PAYW;
            localparam logic [31:0] MASK = (32'd1 << CW) - 32'd1;
            logic [EW-1:0]   ib_head;
            logic [CNTW-1:0] ib_cnt;
            logic            head_ok;

            xb_fifo #(.W(EW), .DEPTH(CAP)) u_inbound (
                .clk(clk), .rst(rst), .push(acc), .din({now, in_pay}),
                .pop(head_ok), .dout(ib_head), .count(ib_cnt)
            );

            assign head_ok   = (ib_cnt != '0) &&
                               xb_pkg::aged(32'(now), 32'(ib_head[EW-1:PAYW]), MASK, 32'(DELAY));
            assign fresh     = head_ok && (rt_cnt == '0);
            assign fresh_pay = ib_head[PAYW-1:0];
            assign rt_push   = head_ok && ((rt_cnt != '0) || !out_rdy);
            assign rt_din    = ib_head[PAYW-1:0];
            assign occ       = OW'(ib_cnt) + OW'(rt_cnt);
        end else begin : g_direct
            assign fresh     = acc && (rt_cnt == '0);
            assign fresh_pay = in_pay;
            assign rt_push   = acc && ((rt_cnt != '0) || !out_rdy);
            assign rt_din    = in_pay;
            assign occ       = OW'(rt_cnt);
        end
    endgenerate

    assign out_vld    = resend || fresh;
    assign out_resend = resend;
    assign out_pay    = resend ? rt_head : fresh_pay;
    assign del        = resend || (fresh && out_rdy);
    assign sum_next   = occ + OW'(acc) - OW'(del);

    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b0;
        else     hold_q <= (sum_next >= OW'(CAP));
    end
endmodule

// File: rtl/xb_relay.sv
module xb_relay (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  logic [1:0] in_code,
    output logic       out_vld,
    output logic [1:0] out_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_code <= 2'd0;
        end else begin
            out_vld  <= in_vld && !xb_pkg::absorbed(in_code);
            out_code <= in_code;
        end
    end
endmodule

// File: rtl/dly_xbridge.sv
module dly_xbridge #(
    parameter int AW     = 16,
    parameter int SW     = 2,
    parameter int DW     = 32,
    parameter int DELAY  = 4,
    parameter int CAP_AB = 16,
    parameter int CAP_BA = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_in_vld,
    output logic          a_in_rdy,
    input  logic [AW-1:0] a_in_addr,
    input  logic [SW-1:0] a_in_size,
    input  logic [DW-1:0] a_in_data,
    output logic          a_out_vld,
    input  logic          a_out_rdy,
    output logic          a_out_resend,
    input  logic          a_retry,
    output logic [AW-1:0] a_out_addr,
    output logic [SW-1:0] a_out_size,
    output logic [DW-1:0] a_out_data,
    output logic          a_hold,
    input  logic          a_st_in_vld,
    input  logic [1:0]    a_st_in_code,
    output logic          a_st_out_vld,
    output logic [1:0]    a_st_out_code,
    input  logic          b_in_vld,
    output logic          b_in_rdy,
    input  logic [AW-1:0] b_in_addr,
    input  logic [SW-1:0] b_in_size,
    input  logic [DW-1:0] b_in_data,
    output logic          b_out_vld,
    input  logic          b_out_rdy,
    output logic          b_out_resend,
    input  logic          b_retry,
    output logic [AW-1:0] b_out_addr,
    output logic [SW-1:0] b_out_size,
    output logic [DW-1:0] b_out_data,
    output logic          b_hold,
    input  logic          b_st_in_vld,
    input  logic [1:0]    b_st_in_code,
    output logic          b_st_out_vld,
    output logic [1:0]    b_st_out_code
);
    localparam int PAYW = AW + SW + DW;
    localparam int CW   = $clog2(DELAY + 1) + 1;

    logic [CW-1:0]   now;
    logic [PAYW-1:0] ab_out, ba_out;

    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + CW'(1);
    end

    xb_lane #(.PAYW(PAYW), .DELAY(DELAY), .CAP(CAP_AB), .CW(CW)) u_ab (
        .clk(clk), .rst(rst), .now(now),
        .in_vld(a_in_vld), .in_rdy(a_in_rdy), .in_pay({a_in_addr, a_in_size, a_in_data}),
        .out_vld(b_out_vld), .out_rdy(b_out_rdy), .out_resend(b_out_resend),
        .retry(b_retry), .out_pay(ab_out), .hold(a_hold)
    );

    xb_lane #(.PAYW(PAYW), .DELAY(DELAY), .CAP(CAP_BA), .CW(CW)) u_ba (
        .clk(clk), .rst(rst), .now(now),
        .in_vld(b_in_vld), .in_rdy(b_in_rdy), .in_pay({b_in_addr, b_in_size, b_in_data}),
        .out_vld(a_out_vld), .out_rdy(a_out_rdy), .out_resend(a_out_resend),
        .retry(a_retry), .out_pay(ba_out), .hold(b_hold)
    );

    assign {b_out_addr, b_out_size, b_out_data} = ab_out;
    assign {a_out_addr, a_out_size, a_out_data} = ba_out;

    xb_relay u_rel_ab (
        .clk(clk), .rst(rst), .in_vld(a_st_in_vld), .in_code(a_st_in_code),
        .out_vld(b_st_out_vld), .out_code(b_st_out_code)
    );

    xb_relay u_rel_ba (
        .clk(clk), .rst(rst), .in_vld(b_st_in_vld), .in_code(b_st_in_code),
        .out_vld(a_st_out_vld), .out_code(a_st_out_code)
    );
endmodule

// File: rtl/dly_xbridge_chk.sv
module dly_xbridge_chk #(
    parameter int CAP_AB = 16,
    parameter int CAP_BA = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       a_in_vld,
    input logic       a_in_rdy,
    input logic       a_hold,
    input logic       a_out_vld,
    input logic       a_out_rdy,
    input logic       a_out_resend,
    input logic       a_retry,
    input logic       a_st_in_vld,
    input logic [1:0] a_st_in_code,
    input logic       a_st_out_vld,
    input logic [1:0] a_st_out_code,
    input logic       b_in_vld,
    input logic       b_in_rdy,
    input logic       b_hold,
    input logic       b_out_vld,
    input logic       b_out_rdy,
    input logic       b_out_resend,
    input logic       b_retry,
    input logic       b_st_in_vld,
    input logic [1:0] b_st_in_code,
    input logic       b_st_out_vld,
    input logic [1:0] b_st_out_code
);
    int fly_ab, fly_ba;
    logic take_ab, take_ba, give_ab, give_ba;

    assign take_ab = a_in_vld && a_in_rdy;
    assign take_ba = b_in_vld && b_in_rdy;
    assign give_ab = b_out_vld && (b_out_rdy || b_out_resend);
    assign give_ba = a_out_vld && (a_out_rdy || a_out_resend);

    always_ff @(posedge clk) begin
        if (rst) begin
            fly_ab <= 0;
            fly_ba <= 0;
        end else begin
            fly_ab <= fly_ab + int'(take_ab) - int'(give_ab);
            fly_ba <= fly_ba + int'(take_ba) - int'(give_ba);
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (fly_ab <= CAP_AB) && (fly_ba <= CAP_BA));

    assert_hold_level_R4: assert property (@(posedge clk) disable iff (rst)
        (a_hold == (fly_ab >= CAP_AB)) && (b_hold == (fly_ba >= CAP_BA)));

    assert_hold_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (a_hold || b_hold) |-> !((a_hold && a_in_rdy) || (b_hold && b_in_rdy)));

    assert_resend_on_retry_R6: assert property (@(posedge clk) disable iff (rst)
        (a_out_resend || b_out_resend) |->
            ((!a_out_resend || (a_retry && a_out_vld)) && (!b_out_resend || (b_retry && b_out_vld))));

    assert_relay_absorb_R9: assert property (@(posedge clk) disable iff (rst)
        (a_st_in_vld && (a_st_in_code == 2'd1 || a_st_in_code == 2'd2)) |=> !b_st_out_vld);

    assert_relay_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (b_st_in_vld && (b_st_in_code == 2'd0 || b_st_in_code == 2'd3)) |=>
            (a_st_out_vld && a_st_out_code == $past(b_st_in_code)));
endmodule

bind dly_xbridge dly_xbridge_chk #(.CAP_AB(CAP_AB), .CAP_BA(CAP_BA)) u_chk (
    .clk(clk), .rst(rst),
    .a_in_vld(a_in_vld), .a_in_rdy(a_in_rdy), .a_hold(a_hold),
    .a_out_vld(a_out_vld), .a_out_rdy(a_out_rdy), .a_out_resend(a_out_resend), .a_retry(a_retry),
    .a_st_in_vld(a_st_in_vld), .a_st_in_code(a_st_in_code),
    .a_st_out_vld(a_st_out_vld), .a_st_out_code(a_st_out_code),
    .b_in_vld(b_in_vld), .b_in_rdy(b_in_rdy), .b_hold(b_hold),
    .b_out_vld(b_out_vld), .b_out_rdy(b_out_rdy), .b_out_resend(b_out_resend), .b_retry(b_retry),
    .b_st_in_vld(b_st_in_vld), .b_st_in_code(b_st_in_code),
    .b_st_out_vld(b_st_out_vld), .b_st_out_code(b_st_out_code)
);

// File: tb/dly_xbridge_bench.sv
`timescale 1ns/100ps
module dly_xbridge_bench;
    localparam int AW = 16, SW = 2, DW = 32;
    localparam int PW = AW + SW + DW;
    localparam int DELAY = 4, CAP_AB = 16, CAP_BA = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // main instance signals
    logic a_in_vld, a_in_rdy, a_out_vld, a_out_rdy, a_out_resend, a_retry, a_hold;
    logic [AW-1:0] a_in_addr, a_out_addr;
    logic [SW-1:0] a_in_size, a_out_size;
    logic [DW-1:0] a_in_data, a_out_data;
    logic a_st_in_vld, a_st_out_vld;
    logic [1:0] a_st_in_code, a_st_out_code;
    logic b_in_vld, b_in_rdy, b_out_vld, b_out_rdy, b_out_resend, b_retry, b_hold;
    logic [AW-1:0] b_in_addr, b_out_addr;
    logic [SW-1:0] b_in_size, b_out_size;
    logic [DW-1:0] b_in_data, b_out_data;
    logic b_st_in_vld, b_st_out_vld;
    logic [1:0] b_st_in_code, b_st_out_code;

    dly_xbridge #(.AW(AW), .SW(SW), .DW(DW), .DELAY(DELAY), .CAP_AB(CAP_AB), .CAP_BA(CAP_BA)) u_dly_xbridge (
        .clk(clk), .rst(rst),
        .a_in_vld(a_in_vld), .a_in_rdy(a_in_rdy), .a_in_addr(a_in_addr), .a_in_size(a_in_size), .a_in_data(a_in_data),
        .a_out_vld(a_out_vld), .a_out_rdy(a_out_rdy), .a_out_resend(a_out_resend), .a_retry(a_retry),
        .a_out_addr(a_out_addr), .a_out_size(a_out_size), .a_out_data(a_out_data), .a_hold(a_hold),
        .a_st_in_vld(a_st_in_vld), .a_st_in_code(a_st_in_code), .a_st_out_vld(a_st_out_vld), .a_st_out_code(a_st_out_code),
        .b_in_vld(b_in_vld), .b_in_rdy(b_in_rdy), .b_in_addr(b_in_addr), .b_in_size(b_in_size), .b_in_data(b_in_data),
        .b_out_vld(b_out_vld), .b_out_rdy(b_out_rdy), .b_out_resend(b_out_resend), .b_retry(b_retry),
        .b_out_addr(b_out_addr), .b_out_size(b_out_size), .b_out_data(b_out_data), .b_hold(b_hold),
        .b_st_in_vld(b_st_in_vld), .b_st_in_code(b_st_in_code), .b_st_out_vld(b_st_out_vld), .b_st_out_code(b_st_out_code)
    );

    // zero-delay instance signals
    logic z_a_in_vld, z_a_in_rdy, z_a_out_vld, z_a_out_resend, z_a_hold;
    logic [AW-1:0] z_a_in_addr, z_a_out_addr;
    logic [SW-1:0] z_a_in_size, z_a_out_size;
    logic [DW-1:0] z_a_in_data, z_a_out_data;
    logic z_a_st_out_vld, z_b_st_out_vld;
    logic [1:0] z_a_st_out_code, z_b_st_out_code;
    logic z_b_in_rdy, z_b_out_vld, z_b_out_rdy, z_b_out_resend, z_b_retry, z_b_hold;
    logic [AW-1:0] z_b_out_addr;
    logic [SW-1:0] z_b_out_size;
    logic [DW-1:0] z_b_out_data;

    dly_xbridge #(.AW(AW), .SW(SW), .DW(DW), .DELAY(0), .CAP_AB(2), .CAP_BA(2)) u_dly_xbridge_zd (
        .clk(clk), .rst(rst),
        .a_in_vld(z_a_in_vld), .a_in_rdy(z_a_in_rdy), .a_in_addr(z_a_in_addr), .a_in_size(z_a_in_size), .a_in_data(z_a_in_data),
        .a_out_vld(z_a_out_vld), .a_out_rdy(1'b1), .a_out_resend(z_a_out_resend), .a_retry(1'b0),
        .a_out_addr(z_a_out_addr), .a_out_size(z_a_out_size), .a_out_data(z_a_out_data), .a_hold(z_a_hold),
        .a_st_in_vld(1'b0), .a_st_in_code(2'd0), .a_st_out_vld(z_a_st_out_vld), .a_st_out_code(z_a_st_out_code),
        .b_in_vld(1'b0), .b_in_rdy(z_b_in_rdy), .b_in_addr('0), .b_in_size('0), .b_in_data('0),
        .b_out_vld(z_b_out_vld), .b_out_rdy(z_b_out_rdy), .b_out_resend(z_b_out_resend), .b_retry(z_b_retry),
        .b_out_addr(z_b_out_addr), .b_out_size(z_b_out_size), .b_out_data(z_b_out_data), .b_hold(z_b_hold),
        .b_st_in_vld(1'b0), .b_st_in_code(2'd0), .b_st_out_vld(z_b_st_out_vld), .b_st_out_code(z_b_st_out_code)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [PW+31:0] q_ab[$];
    logic [PW+31:0] q_ba[$];
    logic exp_b_st_vld = 0, exp_a_st_vld = 0;
    logic [1:0] exp_b_st_code = 0, exp_a_st_code = 0;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] rnd_pay();
        return {16'($urandom), 2'($urandom), 32'($urandom)};
    endfunction

    // per-cycle model: checks against state as of this cycle, then updates
    task automatic monitor();
        logic [PW+31:0] e;
        chk(a_hold == (q_ab.size() >= CAP_AB), "R4", 64'(a_hold), 64'(q_ab.size() >= CAP_AB));
        chk(b_hold == (q_ba.size() >= CAP_BA), "R4", 64'(b_hold), 64'(q_ba.size() >= CAP_BA));
        chk(a_in_rdy == !a_hold, "R5", 64'(a_in_rdy), 64'(!a_hold));
        chk(b_in_rdy == !b_hold, "R5", 64'(b_in_rdy), 64'(!b_hold));
        if (b_out_resend) chk(b_retry, "R6", 64'(b_retry), 64'd1);
        if (a_out_resend) chk(a_retry, "R6", 64'(a_retry), 64'd1);
        chk(q_ab.size() <= CAP_AB && q_ba.size() <= CAP_BA, "R3", 64'(q_ab.size()), 64'(CAP_AB));
        if (b_out_vld && (b_out_rdy || b_out_resend)) begin
            if (q_ab.size() == 0) chk(1'b0, "R1", 64'd1, 64'd0);
            else begin
                e = q_ab.pop_front();
                chk({b_out_addr, b_out_size, b_out_data} == e[PW-1:0], "R1",
                    64'({b_out_addr, b_out_data}), 64'({e[PW-1:PW-AW], e[DW-1:0]}));
                chk(cyc - int'(e[PW+31:PW]) >= DELAY, "R2", 64'(cyc - int'(e[PW+31:PW])), 64'(DELAY));
            end
        end
        if (a_out_vld && (a_out_rdy || a_out_resend)) begin
            if (q_ba.size() == 0) chk(1'b0, "R1", 64'd1, 64'd0);
            else begin
                e = q_ba.pop_front();
                chk({a_out_addr, a_out_size, a_out_data} == e[PW-1:0], "R1",
                    64'({a_out_addr, a_out_data}), 64'({e[PW-1:PW-AW], e[DW-1:0]}));
                chk(cyc - int'(e[PW+31:PW]) >= DELAY, "R2", 64'(cyc - int'(e[PW+31:PW])), 64'(DELAY));
            end
        end
        if (a_in_vld && a_in_rdy) q_ab.push_back({32'(cyc), a_in_addr, a_in_size, a_in_data});
        if (b_in_vld && b_in_rdy) q_ba.push_back({32'(cyc), b_in_addr, b_in_size, b_in_data});
        chk(b_st_out_vld == exp_b_st_vld, "R9", 64'(b_st_out_vld), 64'(exp_b_st_vld));
        if (exp_b_st_vld) chk(b_st_out_code == exp_b_st_code, "R9", 64'(b_st_out_code), 64'(exp_b_st_code));
        chk(a_st_out_vld == exp_a_st_vld, "R9", 64'(a_st_out_vld), 64'(exp_a_st_vld));
        if (exp_a_st_vld) chk(a_st_out_code == exp_a_st_code, "R9", 64'(a_st_out_code), 64'(exp_a_st_code));
        exp_b_st_vld  = a_st_in_vld && (a_st_in_code == 2'd0 || a_st_in_code == 2'd3);
        exp_b_st_code = a_st_in_code;
        exp_a_st_vld  = b_st_in_vld && (b_st_in_code == 2'd0 || b_st_in_code == 2'd3);
        exp_a_st_code = b_st_in_code;
    endtask

    task automatic tick();
        #1;
        monitor();
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle_inputs();
        a_in_vld = 0; b_in_vld = 0; a_st_in_vld = 0; b_st_in_vld = 0;
        a_st_in_code = 0; b_st_in_code = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual running expected finished");
        summary();
    end

    initial begin
        int c0;
        logic [PW-1:0] p;
        void'($urandom(32'd20240611));
        idle_inputs();
        {a_in_addr, a_in_size, a_in_data} = '0;
        {b_in_addr, b_in_size, b_in_data} = '0;
        a_out_rdy = 1; b_out_rdy = 1; a_retry = 0; b_retry = 0;
        z_a_in_vld = 0; {z_a_in_addr, z_a_in_size, z_a_in_data} = '0;
        z_b_out_rdy = 1; z_b_retry = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        // R10: reset state
        #1;
        chk(!a_hold && !b_hold && a_in_rdy && b_in_rdy, "R10", 64'({a_hold, b_hold, a_in_rdy, b_in_rdy}), 64'b0011);
        chk(!a_out_vld && !b_out_vld && !a_st_out_vld && !b_st_out_vld, "R10",
            64'({a_out_vld, b_out_vld, a_st_out_vld, b_st_out_vld}), 64'd0);
        chk(!z_b_out_vld && !z_a_hold, "R10", 64'({z_b_out_vld, z_a_hold}), 64'd0);
        @(negedge clk); cyc++;

        // R2: exact delay on an idle bridge
        a_in_vld = 1; {a_in_addr, a_in_size, a_in_data} = rnd_pay();
        c0 = cyc;
        tick();
        a_in_vld = 0;
        for (int k = 1; k <= DELAY + 2; k++) begin
            #1;
            chk(b_out_vld == (cyc == c0 + DELAY), "R2", 64'(b_out_vld), 64'(cyc == c0 + DELAY));
            monitor();
            @(negedge clk); cyc++;
        end

        // R9: every status code both ways
        for (int c = 0; c < 4; c++) begin
            a_st_in_vld = 1; a_st_in_code = 2'(c);
            b_st_in_vld = 1; b_st_in_code = 2'(3 - c);
            tick();
        end
        idle_inputs();
        tick();

        // R4/R5/R6: starve side B consumer until side A is held
        b_out_rdy = 0; b_retry = 0;
        for (int k = 0; k < CAP_AB + 6; k++) begin
            a_in_vld = 1; {a_in_addr, a_in_size, a_in_data} = rnd_pay();
            tick();
        end
        chk(a_hold == 1'b1, "R4", 64'(a_hold), 64'd1);
        chk(q_ab.size() == CAP_AB, "R5", 64'(q_ab.size()), 64'(CAP_AB));
        a_in_vld = 0;
        b_retry = 1;
        repeat (CAP_AB + DELAY + 4) tick();
        chk(a_hold == 1'b0 && q_ab.size() == 0, "R6", 64'(q_ab.size()), 64'd0);
        b_retry = 0; b_out_rdy = 1;

        // R3: separate smaller capacity in the other direction
        a_out_rdy = 0;
        for (int k = 0; k < CAP_BA + 4; k++) begin
            b_in_vld = 1; {b_in_addr, b_in_size, b_in_data} = rnd_pay();
            tick();
        end
        chk(b_hold == 1'b1 && q_ba.size() == CAP_BA, "R3", 64'(q_ba.size()), 64'(CAP_BA));
        chk(a_hold == 1'b0, "R3", 64'(a_hold), 64'd0);
        b_in_vld = 0;
        a_retry = 1;
        repeat (CAP_BA + DELAY + 4) tick();
        a_retry = 0; a_out_rdy = 1;

        // R1/R2/R6/R7: random traffic, counter wraps many times
        for (int k = 0; k < 4000; k++) begin
            a_in_vld = ($urandom % 10) < 6; {a_in_addr, a_in_size, a_in_data} = rnd_pay();
            b_in_vld = ($urandom % 10) < 5; {b_in_addr, b_in_size, b_in_data} = rnd_pay();
            a_out_rdy = ($urandom % 2) == 0; b_out_rdy = ($urandom % 2) == 0;
            a_retry = ($urandom % 8) == 0;   b_retry = ($urandom % 8) == 0;
            a_st_in_vld = ($urandom % 4) == 0; a_st_in_code = 2'($urandom);
            b_st_in_vld = ($urandom % 4) == 0; b_st_in_code = 2'($urandom);
            tick();
        end
        idle_inputs();
        a_out_rdy = 1; b_out_rdy = 1; a_retry = 1; b_retry = 1;
        repeat (CAP_AB + CAP_BA + DELAY + 10) tick();
        chk(q_ab.size() == 0 && q_ba.size() == 0, "R1", 64'(q_ab.size() + q_ba.size()), 64'd0);

        // R8: zero-delay instance, same-cycle pass-through
        p = rnd_pay();
        z_a_in_vld = 1; {z_a_in_addr, z_a_in_size, z_a_in_data} = p; z_b_out_rdy = 1;
        #1;
        chk(z_b_out_vld && !z_b_out_resend && {z_b_out_addr, z_b_out_size, z_b_out_data} == p, "R8",
            64'(z_b_out_data), 64'(p[DW-1:0]));
        @(negedge clk); cyc++;
        // refused, then resent on retry
        p = rnd_pay();
        {z_a_in_addr, z_a_in_size, z_a_in_data} = p; z_b_out_rdy = 0;
        #1;
        chk(z_b_out_vld == 1'b1, "R8", 64'(z_b_out_vld), 64'd1);
        @(negedge clk); cyc++;
        z_a_in_vld = 0; z_b_retry = 1;
        #1;
        chk(z_b_out_vld && z_b_out_resend && z_b_out_data == p[DW-1:0], "R6", 64'(z_b_out_data), 64'(p[DW-1:0]));
        @(negedge clk); cyc++;
        #1;
        chk(!z_b_out_vld, "R6", 64'(z_b_out_vld), 64'd0);
        @(negedge clk); cyc++;
        // zero-delay hold with capacity 2
        z_b_retry = 0; z_b_out_rdy = 0; z_a_in_vld = 1;
        repeat (2) begin
            {z_a_in_addr, z_a_in_size, z_a_in_data} = rnd_pay();
            @(negedge clk); cyc++;
        end
        #1;
        chk(z_a_hold && !z_a_in_rdy, "R4", 64'({z_a_hold, z_a_in_rdy}), 64'b10);
        @(negedge clk); cyc++;
        z_a_in_vld = 0; z_b_retry = 1;
        repeat (3) begin @(negedge clk); cyc++; end
        #1;
        chk(!z_a_hold, "R4", 64'(z_a_hold), 64'd0);
        summary();
    end
endmodule